// File: doc/BRIEF.md
# Word-Serial Pseudonoise Sliding Correlator

This block sits in the digital baseband of a pulsed radio receiver. Low-resolution signed samples arrive one per pulse frame. A serial-to-parallel stage gathers them into a word that is one code length long. When the word is full, it is copied into a hold register. The hold register is the operand for every correlation request until the next word completes.

A request consists of a start pulse, a rotation index and a code word. The block multiplies each chip of the held word by plus or minus one, as set by the rotated code bit. It adds the products in clusters of four, then reduces the cluster sums through a registered binary tree. A search controller can therefore step the code through every cyclic alignment, one alignment per cycle, against the same stored word. In the default case this takes 32 back-to-back requests.

A mode input selects what is stored per chip:
- the first-position sample alone, for antipodal (BPSK) signalling;
- the difference between the two pulse-position samples, for binary PPM.

For BPSK, one instance of this block serves each quadrature branch.

The code length must be a power of two and larger than the cluster size.

Top module: `pns_slide_corr`

## Requirements
- R1: After reset, `corr_valid` is 0 and `corr_sum` is 0 until the first result arrives.
- R2: A sample is taken only in a cycle with `smp_valid` high. The k-th sample taken since the last reload (k = 0..NS-1) becomes chip k. When the NS-th sample is taken, the collected word replaces the held word at that same clock edge.
- R3: With `mode` = 0 (BPSK) at capture, the chip equals `smp_a` as a signed two's-complement value, and `smp_b` has no effect.
- R4: With `mode` = 1 (PPM) at capture, the chip equals `smp_a` − `smp_b`, both taken as signed values.
- R5: Each chip is added when its rotated code bit is 1 and subtracted when that bit is 0.
- R6: With rotation r, chip i is weighted by code bit `code[(i + r) mod NS]`. This is a cyclic left shift of the code by r places.
- R7: `corr_valid` is high exactly 4 cycles after each cycle in which `start` is high, and at no other time. A new start is accepted every cycle, and each start uses the word held when it is sampled.
- R8: `corr_sum` is a 10-bit signed value. It reaches ±256 for a BPSK word of all −8 samples and ±480 for a PPM word of chips of 15, with no wrap.
- R9: The held word, and therefore every result, is unchanged while fewer than NS new samples have been taken, however many rotations are requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per pulse frame |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Qualifies the sample inputs |
| smp_a | input | 4 | Signed sample, first pulse position or branch sample |
| smp_b | input | 4 | Signed sample, second pulse position (PPM only) |
| mode | input | 1 | 0 = BPSK, 1 = PPM difference, applied at capture |
| code | input | 32 | Spreading code word, bit i for chip i |
| rot | input | 5 | Cyclic rotation of the code for this request |
| start | input | 1 | Requests one correlation |
| corr_valid | output | 1 | Result strobe |
| corr_sum | output | 10 | Signed correlation result |

## Verification
The assertions assume `start` is held low while reset is active. Under that assumption, every strobe can be traced to a request exactly four cycles earlier. The magnitude bound assumes the samples come from the signed 4-bit range, so a PPM chip never exceeds ±15. The stimulus always drives 4-bit two's-complement values. It feeds samples with random gaps, also during rotation sweeps, so reloads land at arbitrary points between requests. The bench never raises `start` during reset.

// File: rtl/pns_pkg.sv
package pns_pkg;
    typedef enum logic {
        MODE_BPSK = 1'b0,
        MODE_PPM  = 1'b1
    } corr_mode_e;
endpackage

// File: rtl/pns_sp_buf.sv
module pns_sp_buf
    import pns_pkg::*;
#(
    parameter int NS = 32,
    parameter int BA = 4,
    localparam int CW = BA + 1,
    localparam int RW = $clog2(NS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_valid,
    input  logic [BA-1:0]          smp_a,
    input  logic [BA-1:0]          smp_b,
    input  logic                   mode,
    output logic [NS-1:0][CW-1:0]  word_o
);
    typedef struct packed {
        logic [RW-1:0]          cnt;
        logic [NS-1:0][CW-1:0]  col;
        logic [NS-1:0][CW-1:0]  hold;
    } sp_st_t;

    sp_st_t st_d, st_q;
    logic signed [CW-1:0] chip;

    always_comb begin
        if (mode == MODE_PPM)
            chip = $signed({smp_a[BA-1], smp_a}) - $signed({smp_b[BA-1], smp_b});
        else
            chip = $signed({smp_a[BA-1], smp_a});
        st_d = st_q;
        if (smp_valid) begin
            st_d.col[st_q.cnt] = chip;
            if (st_q.cnt == RW'(NS - 1)) begin
                st_d.cnt  = '0;
                st_d.hold = st_d.col;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = st_q.hold;

    // R9: held word only moves on the sample that completes a word
    assert_hold_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_valid && st_q.cnt == RW'(NS - 1)) |=> $stable(st_q.hold));

    // R2: completing a word restarts collection at chip 0
    assert_reload_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && st_q.cnt == RW'(NS - 1)) |=> (st_q.cnt == '0));
endmodule

// File: rtl/pns_grp_mul.sv
module pns_grp_mul #(
    parameter int NS  = 32,
    parameter int BA  = 4,
    parameter int GRP = 4,
    parameter int OW  = 10,
    localparam int CW = BA + 1,
    localparam int RW = $clog2(NS),
    localparam int NG = NS / GRP
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [RW-1:0]          rot,
    input  logic [NS-1:0]          code,
    input  logic [NS-1:0][CW-1:0]  word_i,
    output logic                   grp_vld,
    output logic [NG-1:0][OW-1:0]  grp_sum
);
    typedef struct packed {
        logic                   vld;
        logic [NG-1:0][OW-1:0]  sum;
    } grp_st_t;

    grp_st_t st_d, st_q;
    logic [NS-1:0]         code_r;
    logic [RW-1:0]         pos;
    logic signed [CW-1:0]  chipv;
    logic signed [OW-1:0]  term;
    logic signed [OW-1:0]  acc;

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            pos       = RW'(i) + rot;
            code_r[i] = code[pos];
        end
        st_d     = st_q;
        st_d.vld = start;
        chipv    = '0;
        term     = '0;
        acc      = '0;
        if (start) begin
            for (int g = 0; g < NG; g++) begin
                acc = '0;
                for (int k = 0; k < GRP; k++) begin
                    chipv = $signed(word_i[g*GRP + k]);
                    term  = code_r[g*GRP + k] ? OW'(chipv) : -OW'(chipv);
                    acc   = acc + term;
                end
                st_d.sum[g] = acc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grp_vld = st_q.vld;
    assign grp_sum = st_q.sum;
endmodule

// File: rtl/pns_add_tree.sv
module pns_add_tree #(
    parameter int NG = 8,
    parameter int OW = 10,
    localparam int LV = $clog2(NG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_vld,
    input  logic [NG-1:0][OW-1:0]  in_sum,
    output logic                   out_vld,
    output logic [OW-1:0]          out_sum
);
    for (genvar l = 0; l < LV; l++) begin : g_lvl
        localparam int N = NG >> (l + 1);

        typedef struct packed {
            logic                  v;
            logic [N-1:0][OW-1:0]  s;
        } stage_t;

        stage_t                   st_d, st_q;
        logic                     src_vld;
        logic [2*N-1:0][OW-1:0]   src;

        if (l == 0) begin : g_src
            assign src_vld = in_vld;
            assign src     = in_sum;
        end else begin : g_src
            assign src_vld = g_lvl[l-1].st_q.v;
            assign src     = g_lvl[l-1].st_q.s;
        end

        always_comb begin
            st_d   = st_q;
            st_d.v = src_vld;
            if (src_vld) begin
                for (int j = 0; j < N; j++)
                    st_d.s[j] = src[2*j] + src[2*j + 1];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end
    end

    assign out_vld = g_lvl[LV-1].st_q.v;
    assign out_sum = g_lvl[LV-1].st_q.s[0];
endmodule

// File: rtl/pns_slide_corr.sv
module pns_slide_corr #(
    parameter int NS  = 32,
    parameter int BA  = 4,
    parameter int GRP = 4,
    localparam int RW = $clog2(NS),
    localparam int OW = BA + RW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_valid,
    input  logic [BA-1:0]   smp_a,
    input  logic [BA-1:0]   smp_b,
    input  logic            mode,
    input  logic [NS-1:0]   code,
    input  logic [RW-1:0]   rot,
    input  logic            start,
    output logic            corr_valid,
    output logic [OW-1:0]   corr_sum
);
    localparam int CW  = BA + 1;
    localparam int NG  = NS / GRP;
    localparam int LAT = $clog2(NG) + 1;
    localparam int LIM = NS * ((1 << BA) - 1);

    logic [NS-1:0][CW-1:0] word;
    logic                  grp_vld;
    logic [NG-1:0][OW-1:0] grp_sum;

    pns_sp_buf #(.NS(NS), .BA(BA)) u_sp (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_a     (smp_a),
        .smp_b     (smp_b),
        .mode      (mode),
        .word_o    (word)
    );

    pns_grp_mul #(.NS(NS), .BA(BA), .GRP(GRP), .OW(OW)) u_grp (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .rot     (rot),
        .code    (code),
        .word_i  (word),
        .grp_vld (grp_vld),
        .grp_sum (grp_sum)
    );

    pns_add_tree #(.NG(NG), .OW(OW)) u_tree (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (grp_vld),
        .in_sum  (grp_sum),
        .out_vld (corr_valid),
        .out_sum (corr_sum)
    );

    // R7: every request yields a strobe after the full pipeline
    assert_start_to_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ##(LAT) corr_valid);

    // R7: no strobe without a matching request
    assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |-> $past(start, LAT));

    // R8: result magnitude stays inside the reachable range
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |-> ($signed(corr_sum) <= LIM && $signed(corr_sum) >= -LIM));
endmodule

// File: tb/sim_pns_slide_corr.sv
module sim_pns_slide_corr;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 32;
    localparam int BA = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [3:0]  smp_a = '0;
    logic [3:0]  smp_b = '0;
    logic        mode = 1'b0;
    logic [31:0] code = '0;
    logic [4:0]  rot = '0;
    logic        start = 1'b0;
    logic        corr_valid;
    logic [9:0]  corr_sum;

    int n_vec = 0;
    int n_bad = 0;
    int hold_m [NS];
    int col_m  [NS];
    int cnt_m  = 0;
    bit    pv [1:4];
    int    ps [1:4];
    string pt [1:4];

    pns_slide_corr u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_a(smp_a),
        .smp_b(smp_b), .mode(mode), .code(code), .rot(rot), .start(start),
        .corr_valid(corr_valid), .corr_sum(corr_sum)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    function automatic int model(input logic [31:0] c, input int r);
        int s = 0;
        for (int i = 0; i < NS; i++)
            s += c[(i + r) % NS] ? hold_m[i] : -hold_m[i];
        return s;
    endfunction

    task automatic step(input bit st, input int r, input logic [31:0] c,
                        input bit sv, input int a, input int b, input bit m,
                        input string tag);
        @(negedge clk);
        if (pv[4] || corr_valid) begin
            n_vec++;
            if (corr_valid !== pv[4] || (pv[4] && $signed(corr_sum) != ps[4])) begin
                n_bad++;
                $display("FAIL %s: valid=%0b sum=%0d expected valid=%0b sum=%0d",
                         pt[4], corr_valid, $signed(corr_sum), pv[4], ps[4]);
            end
        end
        for (int k = 4; k > 1; k--) begin
            pv[k] = pv[k-1]; ps[k] = ps[k-1]; pt[k] = pt[k-1];
        end
        pv[1] = st;
        ps[1] = st ? model(c, r) : 0;
        pt[1] = tag;
        start = st; rot = r[4:0]; code = c;
        smp_valid = sv; smp_a = a[3:0]; smp_b = b[3:0]; mode = m;
        if (sv) begin
            col_m[cnt_m] = m ? (a - b) : a;
            cnt_m++;
            if (cnt_m == NS) begin
                hold_m = col_m;
                cnt_m = 0;
            end
        end
    endtask

    function automatic int rnd4();
        return int'($urandom_range(15)) - 8;
    endfunction

    // R2: load a word sample by sample, with idle gaps carrying junk data
    task automatic load_word(input int a_fix, input int b_fix, input bit m, input bit rnd);
        for (int i = 0; i < NS; i++) begin
            if (i % 5 == 2) step(0, 0, 0, 0, rnd4(), rnd4(), ~m, "R2");
            step(0, 0, 0, 1, rnd ? rnd4() : a_fix, rnd ? rnd4() : b_fix, m, "R2");
        end
    endtask

    initial begin
        for (int k = 1; k <= 4; k++) begin pv[k] = 0; ps[k] = 0; pt[k] = ""; end
        for (int i = 0; i < NS; i++) begin hold_m[i] = 0; col_m[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_vec++;  // R1: reset state
        if (corr_valid !== 1'b0 || corr_sum !== '0) begin
            n_bad++;
            $display("FAIL R1: valid=%0b sum=%0d expected valid=0 sum=0",
                     corr_valid, $signed(corr_sum));
        end
        // R1: a request on an all-zero held word
        step(1, 0, 32'hA5A5_5A5A, 0, 0, 0, 0, "R1");

        // R3/R8: BPSK word of -8 with random second-position input ignored
        for (int i = 0; i < NS; i++) step(0, 0, 0, 1, -8, rnd4(), 0, "R3");
        step(1, 0, 32'h0000_0000, 0, 0, 0, 0, "R8");
        step(1, 7, 32'hFFFF_FFFF, 0, 0, 0, 0, "R8");
        step(1, 3, 32'h0000_0001, 0, 0, 0, 0, "R5");

        // R4/R8: PPM word of 15 per chip
        load_word(7, -8, 1, 0);
        step(1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, "R8");
        step(1, 9, 32'h0000_0000, 0, 0, 0, 0, "R8");
        step(1, 0, 32'h8000_0000, 0, 0, 0, 0, "R6");

        // R4: random PPM word, then R5/R6 single-bit codes at each rotation
        load_word(0, 0, 1, 1);
        for (int r = 0; r < NS; r++)
            step(1, r, 32'h0000_0001 << (r % 7), 0, 0, 0, 0, "R6");

        // R7/R9: full rotation sweeps back to back with samples arriving alongside
        for (int w = 0; w < 6; w++) begin
            load_word(0, 0, w[0], 1);
            for (int c = 0; c < 3; c++) begin
                logic [31:0] cw = $urandom();
                for (int r = 0; r < NS; r++)
                    step(1, r, cw, ($urandom_range(3) == 0), rnd4(), rnd4(),
                         $urandom_range(1) == 1, "R9");
            end
        end

        // R7: isolated requests separated by idle cycles
        for (int i = 0; i < 4; i++) begin
            step(1, i * 5, $urandom(), 0, 0, 0, 0, "R7");
            repeat (i + 1) step(0, 0, 0, 0, 0, 0, 0, "R7");
        end
        repeat (6) step(0, 0, 0, 0, 0, 0, 0, "R7");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule